// File: doc/BRIEF.md
# Power-On and Stop-Mode Wake Sequencer

This block owns the reset and clock-gating state of a small controller core. When power becomes good it keeps the rest of the chip in reset for a fixed stabilisation window of 2^CNT_W clocks, and it records that a power-on event took place. The default window is 65,536 clocks. After release, software may request stop mode. The sequencer then gates the internal clock enable off until a qualifying external interrupt edge arrives. It runs the same stabilisation window before it turns the clocks back on.

Six external interrupt lines are watched: indexes 0 to 5. Lines 2 and 4 qualify on a rising edge and the others on a falling edge. All lines pass through a two-flop resynchroniser. The sequencer reports which line ended the last stop period. An active-high reset pin, sampled on `clk_i`, can cut in at any point and restart the hold window. The power-on flag is kept until software clears it.

Top module: `pwr_wake_seq`

## Requirements
- R1: After `rst_ni` rises, `sys_rst_o` stays 1 for exactly 2^CNT_W rising clock edges and is 0 after the next one. `clk_en_o` stays 1 throughout.
- R2: `rst_ni` low sets `por_flag_o` to 1. `por_clr_i` high clears it at the next edge. A pin reset through `ext_rst_i` leaves it unchanged.
- R3: `ext_rst_i` high forces the hold state from the next edge: `sys_rst_o`=1, `clk_en_o`=1, `stop_bit_o`=0 and `wake_src_o`=0. Release comes 2^CNT_W edges after the first edge that sees the pin low.
- R4: `stop_set_i` high while running gives `clk_en_o`=0, `stop_bit_o`=1 and `wake_src_o`=0 at the next edge. During the reset hold it is ignored.
- R5: In stop mode, a rising edge on line 2 or 4, or a falling edge on line 0, 1, 3 or 5, starts the wake sequence. This happens at the third rising edge after the pin changes, because of two synchroniser flops and one edge register.
- R6: Neither an edge in the opposite direction on a line nor an edge seen while running starts a wake.
- R7: Once the wake sequence has started, `clk_en_o` stays 0 for 2^CNT_W edges. It then returns to 1 and `stop_bit_o` clears by itself.
- R8: `wake_src_o` is one-hot, with bit n meaning line n. When several lines qualify in the same cycle, the lowest index wins. The value holds until the next stop entry or reset.
- R9: An `ext_rst_i` pulse during stop or during the wake count abandons it and follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running raw clock |
| rst_ni | input | 1 | Power-good, active low, asynchronous |
| ext_rst_i | input | 1 | Reset pin, active high, synchronous |
| stop_set_i | input | 1 | Software write of 1 to the stop control bit |
| por_clr_i | input | 1 | Software write of 0 to the power-on flag |
| int_lvl_i | input | NUM_INT | External interrupt line levels |
| sys_rst_o | output | 1 | Internal reset, active high |
| clk_en_o | output | 1 | Internal clock enable |
| stop_bit_o | output | 1 | Stop control bit readback |
| por_flag_o | output | 1 | Power-on flag |
| wake_src_o | output | NUM_INT | One-hot line that ended the last stop |

## Verification
The bench sweeps every line in both edge directions. An inverted polarity mask would wake on the wrong edge or sleep through the right one. It then tries every pair of simultaneous edges. A priority encoder reversed or left unmasked would report the wrong or several bits. The hold and wake windows are checked one edge before and one edge after their end, which catches a window that is one edge off. Reset pulses are placed inside stop and inside the wake count. A design that let the count finish, or that kept the stop bit set, would leave the clocks gated or release them early.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2,
    ST_WAKE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int unsigned NUM_INT = 6,
  parameter logic [NUM_INT-1:0] RISE_MASK = 6'b010100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] lvl_i,
  input  logic               arm_i,
  output logic [NUM_INT-1:0] hit_o
);
  localparam logic [NUM_INT-1:0] IDLE_LVL = ~RISE_MASK;

  for (genvar g = 0; g < NUM_INT; g++) begin : g_line
    logic s0_q, s1_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q   <= IDLE_LVL[g];
        s1_q   <= IDLE_LVL[g];
        prev_q <= IDLE_LVL[g];
      end else begin
        s0_q   <= lvl_i[g];
        s1_q   <= s0_q;
        prev_q <= s1_q;
      end
    end

    if (RISE_MASK[g]) begin : g_rise
      assign hit_o[g] = arm_i & s1_q & ~prev_q;
    end else begin : g_fall
      assign hit_o[g] = arm_i & ~s1_q & prev_q;
    end
  end
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  assign done_o = en_i && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pwr_wake_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_INT = 6,
  parameter logic [NUM_INT-1:0] RISE_MASK = 6'b010100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               stop_set_i,
  input  logic               por_clr_i,
  input  logic [NUM_INT-1:0] int_lvl_i,
  output logic               sys_rst_o,
  output logic               clk_en_o,
  output logic               stop_bit_o,
  output logic               por_flag_o,
  output logic [NUM_INT-1:0] wake_src_o
);
  localparam logic [NUM_INT-1:0] ONE = NUM_INT'(1);

  seq_state_e         state_q, state_d;
  logic [NUM_INT-1:0] wake_q, wake_d, hit, first_hit;
  logic               por_q, cnt_en, cnt_done;

  wake_edge_det #(.NUM_INT(NUM_INT), .RISE_MASK(RISE_MASK)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (int_lvl_i),
    .arm_i (state_q == ST_STOP),
    .hit_o (hit)
  );

  assign cnt_en = !ext_rst_i && ((state_q == ST_HOLD) || (state_q == ST_WAKE));

  stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cnt_en),
    .done_o(cnt_done)
  );

  // isolate lowest set bit: lowest line index wins
  assign first_hit = hit & (~hit + ONE);

  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    if (ext_rst_i) begin
      state_d = ST_HOLD;
      wake_d  = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: if (cnt_done) state_d = ST_RUN;
        ST_RUN: if (stop_set_i) begin
          state_d = ST_STOP;
          wake_d  = '0;
        end
        ST_STOP: if (|hit) begin
          state_d = ST_WAKE;
          wake_d  = first_hit;
        end
        ST_WAKE: if (cnt_done) state_d = ST_RUN;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      wake_q  <= '0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        por_q <= 1'b1;
    else if (por_clr_i) por_q <= 1'b0;
  end

  assign sys_rst_o  = (state_q == ST_HOLD);
  assign clk_en_o   = (state_q == ST_HOLD) || (state_q == ST_RUN);
  assign stop_bit_o = (state_q == ST_STOP) || (state_q == ST_WAKE);
  assign por_flag_o = por_q;
  assign wake_src_o = wake_q;
endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_INT = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ext_rst_i,
  input logic               stop_set_i,
  input logic               por_clr_i,
  input logic               sys_rst_o,
  input logic               clk_en_o,
  input logic               stop_bit_o,
  input logic               por_flag_o,
  input logic [NUM_INT-1:0] wake_src_o
);
  localparam logic [CNT_W:0] LOW_MIN = {1'b1, {CNT_W{1'b0}}};

  logic           started_q;
  logic [CNT_W:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      started_q <= 1'b1;
      if (clk_en_o || sys_rst_o)  low_cnt_q <= '0;
      else if (low_cnt_q != '1)   low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // R1
  hold_clocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (clk_en_o && !stop_bit_o && (wake_src_o == '0)));

  // R2
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_clr_i |=> !por_flag_o);

  // R2
  por_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(!por_flag_o)) |-> !por_flag_o);

  // R3
  pin_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> sys_rst_o);

  // R4
  gate_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $past(stop_set_i));

  // R7
  wake_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_en_o) && !sys_rst_o) |-> (low_cnt_q >= LOW_MIN && !stop_bit_o));

  // R8
  wake_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wake_src_o));

  // R8
  wake_named_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_en_o) && !sys_rst_o) |-> ($countones(wake_src_o) == 1));
endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(.CNT_W(CNT_W), .NUM_INT(NUM_INT)) u_chk (.*);

// File: tb/pwr_wake_seq_tb.sv
module pwr_wake_seq_tb;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned NUM_INT = 6;
  localparam logic [NUM_INT-1:0] RISE_MASK = 6'b010100;
  localparam logic [NUM_INT-1:0] IDLE = ~RISE_MASK;
  localparam int unsigned WIN = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst_i = 1'b0, stop_set_i = 1'b0, por_clr_i = 1'b0;
  logic [NUM_INT-1:0] int_lvl_i = IDLE;
  logic sys_rst_o, clk_en_o, stop_bit_o, por_flag_o;
  logic [NUM_INT-1:0] wake_src_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pwr_wake_seq #(.CNT_W(CNT_W), .NUM_INT(NUM_INT), .RISE_MASK(RISE_MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst_i), .stop_set_i(stop_set_i),
    .por_clr_i(por_clr_i), .int_lvl_i(int_lvl_i), .sys_rst_o(sys_rst_o),
    .clk_en_o(clk_en_o), .stop_bit_o(stop_bit_o), .por_flag_o(por_flag_o),
    .wake_src_o(wake_src_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic enter_stop();
    stop_set_i = 1'b1;
    tick(1);
    stop_set_i = 1'b0;
    chk("R4 clk_en after stop", clk_en_o, 0);
    chk("R4 stop_bit set", stop_bit_o, 1);
    chk("R4 wake_src cleared", wake_src_o, 0);
  endtask

  task automatic hold_release(input string req);
    tick(WIN - 1);
    chk({req, " still in reset"}, sys_rst_o, 1);
    tick(1);
    chk({req, " released"}, sys_rst_o, 0);
    chk({req, " clocks on"}, clk_en_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset sys_rst", sys_rst_o, 1);
    chk("R1 reset clk_en", clk_en_o, 1);
    chk("R2 reset por", por_flag_o, 1);
    chk("R4 reset stop_bit", stop_bit_o, 0);
    chk("R8 reset wake_src", wake_src_o, 0);
    rst_ni = 1'b1;
    hold_release("R1");
    chk("R2 por kept", por_flag_o, 1);

    por_clr_i = 1'b1;
    tick(1);
    por_clr_i = 1'b0;
    chk("R2 por cleared", por_flag_o, 0);

    // pin reset while running, stop request during hold ignored
    ext_rst_i = 1'b1;
    tick(1);
    chk("R3 pin reset", sys_rst_o, 1);
    tick(3);
    ext_rst_i = 1'b0;
    tick(2);
    stop_set_i = 1'b1;
    tick(1);
    stop_set_i = 1'b0;
    chk("R4 stop ignored in hold", stop_bit_o, 0);
    tick(WIN - 4);
    chk("R3 still in reset", sys_rst_o, 1);
    tick(1);
    chk("R3 released", sys_rst_o, 0);
    chk("R4 clocks on after ignored stop", clk_en_o, 1);
    chk("R2 por unaffected by pin", por_flag_o, 0);

    // every line, wrong direction then right direction
    for (int i = 0; i < NUM_INT; i++) begin
      int_lvl_i[i] = ~IDLE[i];
      tick(4);
      chk("R6 run edge no gating", clk_en_o, 1);
      enter_stop();
      int_lvl_i[i] = IDLE[i];
      tick(6);
      chk("R6 wrong edge no wake", clk_en_o, 0);
      chk("R6 wrong edge stop kept", stop_bit_o, 1);
      int_lvl_i[i] = ~IDLE[i];
      tick(3);
      chk("R5 wake source", wake_src_o, 32'(1) << i);
      chk("R5 stop bit in wake", stop_bit_o, 1);
      tick(WIN - 1);
      chk("R7 gated before window", clk_en_o, 0);
      tick(1);
      chk("R7 clocks back", clk_en_o, 1);
      chk("R7 stop auto clear", stop_bit_o, 0);
      int_lvl_i[i] = IDLE[i];
      tick(4);
      chk("R8 wake_src held", wake_src_o, 32'(1) << i);
    end

    // every pair at once: lowest index wins
    for (int a = 0; a < NUM_INT; a++) begin
      for (int b = a + 1; b < NUM_INT; b++) begin
        enter_stop();
        int_lvl_i[a] = ~IDLE[a];
        int_lvl_i[b] = ~IDLE[b];
        tick(3);
        chk("R8 priority", wake_src_o, 32'(1) << a);
        tick(WIN);
        chk("R7 pair clocks back", clk_en_o, 1);
        int_lvl_i = IDLE;
        tick(4);
      end
    end

    // reset inside the wake count
    enter_stop();
    int_lvl_i[2] = 1'b1;
    tick(3 + 5);
    chk("R9 mid-count gated", clk_en_o, 0);
    ext_rst_i = 1'b1;
    tick(1);
    ext_rst_i = 1'b0;
    int_lvl_i = IDLE;
    chk("R9 reset during wake", sys_rst_o, 1);
    chk("R9 stop cleared", stop_bit_o, 0);
    chk("R9 wake_src cleared", wake_src_o, 0);
    hold_release("R9");

    // reset inside stop
    enter_stop();
    tick(5);
    ext_rst_i = 1'b1;
    tick(1);
    ext_rst_i = 1'b0;
    chk("R9 reset during stop", sys_rst_o, 1);
    chk("R9 clocks on in hold", clk_en_o, 1);
    hold_release("R9 stop");
    chk("R2 por after pin resets", por_flag_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule